// File: doc/BRIEF.md
# Sleep and Reset-Cause Status Controller

This block tracks whether the device is in power-down (sleep) and keeps three status flags that let software work out why the last reset happened. The flags are a time-out flag (`flag_to`), a power-down flag (`flag_pd`) and a wake-on-change flag (`flag_wuf`). A sleep command stops the oscillator and marks the device as asleep. While the device sleeps, an external reset, an enabled watchdog time-out or an enabled pin-change request wakes it.

Every reset source writes its own flag pattern, and some sources leave a flag unchanged, so each cause can be told apart afterwards. The watchdog clear is pulsed when the device enters sleep and again on every wake. The core reset request is raised one cycle after the flags are written. The watchdog counter, the oscillator and the core sit outside this block. No output of the block acts as an external reset pin, so a watchdog reset cannot drive that pin.

All inputs are single-cycle synchronous strobes, sampled on the rising edge of `clk`. The registered outputs change on the same edge. `rst_n` is the asynchronous register reset and loads the power-up state.

Top module: `pdn_cause_ctl`

## Requirements
- R1: After `rst_n` is deasserted, and after any cycle with `por_evt` high, the flags read wuf=0, to=1, pd=1, with `asleep`=0 and `osc_en`=1. `por_evt` takes precedence over every other input.
- R2: A `sleep_cmd` while awake, with no reset event in the same cycle, sets to=1 and pd=0 and leaves wuf unchanged. It also sets `asleep`=1, clears `osc_en` and raises `wdt_clr` for one cycle. All of this is visible after that clock edge.
- R3: While asleep, `wdt_tmo` with `wdt_en`=1 wakes the device with wuf=0, to=0, pd=0. With `wdt_en`=0 the device stays asleep and the flags do not change.
- R4: While asleep, `ext_rst` wakes the device with wuf=0, to=1, pd=0.
- R5: While asleep, `pin_chg` with `woc_en`=1 wakes the device with wuf=1, to=1, pd=0. With `woc_en`=0 it has no effect.
- R6: While awake, `wdt_tmo` with `wdt_en`=1 sets wuf=0 and to=0, leaves pd unchanged, and causes a core reset request.
- R7: While awake, `ext_rst` clears wuf, leaves to and pd unchanged, and causes a core reset request.
- R8: Every wake from sleep, whatever its source, clears `asleep`, sets `osc_en` and pulses `wdt_clr` on the same edge that writes the flags.
- R9: Every reset event (power-up, external, watchdog, or a pin-change wake) raises `core_rst_req` in the cycle after the flag update, and only then.
- R10: When several events arrive in one cycle, the order of precedence is `por_evt` > `ext_rst` > watchdog > pin change. Any reset event overrides a `sleep_cmd` in the same cycle, and the device stays awake.
- R11: In a cycle with no event the flags hold their values. `pin_chg` while awake and `sleep_cmd` while asleep have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset, loads the power-up state |
| por_evt | input | 1 | Power-on event strobe |
| ext_rst | input | 1 | Filtered external reset request strobe |
| wdt_tmo | input | 1 | Watchdog time-out strobe |
| wdt_en | input | 1 | Watchdog enabled |
| sleep_cmd | input | 1 | Sleep command strobe |
| pin_chg | input | 1 | Pin-change wake request |
| woc_en | input | 1 | Wake-on-change enabled |
| flag_to | output | 1 | Time-out flag (0 after a watchdog reset) |
| flag_pd | output | 1 | Power-down flag (0 after sleep was entered) |
| flag_wuf | output | 1 | Wake-on-change flag |
| asleep | output | 1 | Device is in sleep |
| osc_en | output | 1 | Oscillator enable |
| wdt_clr | output | 1 | One-cycle watchdog clear pulse |
| core_rst_req | output | 1 | One-cycle core reset request |

## Verification
Two kinds of event can land in the same cycle. In the first, a sleep command coincides with a reset source. In the second, several wake sources arrive together while the device sleeps. The bench drives the sleep command and an external reset on one edge and expects the awake external-reset pattern, with the device still awake. It then drives external, watchdog and pin-change strobes together while asleep and expects the external-wake pattern. Dropping the external reset from that mix must give the watchdog pattern instead of the pin-change one. The expected core reset request one cycle later confirms that only one reset event was recorded.

// File: rtl/pdn_cause_ctl.sv
module pdn_cause_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic por_evt,
  input  logic ext_rst,
  input  logic wdt_tmo,
  input  logic wdt_en,
  input  logic sleep_cmd,
  input  logic pin_chg,
  input  logic woc_en,
  output logic flag_to,
  output logic flag_pd,
  output logic flag_wuf,
  output logic asleep,
  output logic osc_en,
  output logic wdt_clr,
  output logic core_rst_req
);

  logic wdt_hit, pin_hit, rst_ev, enter, rst_d;

  assign wdt_hit = wdt_tmo & wdt_en;
  assign pin_hit = pin_chg & woc_en & asleep;
  assign rst_ev  = por_evt | ext_rst | wdt_hit | pin_hit;
  assign enter   = sleep_cmd & ~asleep & ~rst_ev;   // R10: reset beats sleep

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_wuf <= 1'b0;
      flag_to  <= 1'b1;
      flag_pd  <= 1'b1;
    end else if (por_evt) begin                     // R1
      flag_wuf <= 1'b0;
      flag_to  <= 1'b1;
      flag_pd  <= 1'b1;
    end else if (ext_rst) begin                     // R4 / R7
      flag_wuf <= 1'b0;
      if (asleep) begin
        flag_to <= 1'b1;
        flag_pd <= 1'b0;
      end
    end else if (wdt_hit) begin                     // R3 / R6
      flag_wuf <= 1'b0;
      flag_to  <= 1'b0;
      if (asleep) flag_pd <= 1'b0;
    end else if (pin_hit) begin                     // R5
      flag_wuf <= 1'b1;
      flag_to  <= 1'b1;
      flag_pd  <= 1'b0;
    end else if (enter) begin                       // R2
      flag_to  <= 1'b1;
      flag_pd  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep       <= 1'b0;
      osc_en       <= 1'b1;
      wdt_clr      <= 1'b0;
      rst_d        <= 1'b0;
      core_rst_req <= 1'b0;
    end else begin
      if (enter) begin
        asleep <= 1'b1;
        osc_en <= 1'b0;
      end else if (rst_ev) begin                    // R8
        asleep <= 1'b0;
        osc_en <= 1'b1;
      end
      wdt_clr      <= enter | (asleep & rst_ev);
      rst_d        <= rst_ev;
      core_rst_req <= rst_d;                        // R9
    end
  end

endmodule

// File: rtl/pdn_cause_chk.sv
module pdn_cause_chk (
  input logic clk,
  input logic rst_n,
  input logic por_evt,
  input logic ext_rst,
  input logic wdt_tmo,
  input logic wdt_en,
  input logic sleep_cmd,
  input logic pin_chg,
  input logic woc_en,
  input logic flag_to,
  input logic flag_pd,
  input logic flag_wuf,
  input logic asleep,
  input logic osc_en,
  input logic wdt_clr,
  input logic core_rst_req
);

  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> (flag_to && !flag_pd && wdt_clr && !osc_en));

  p_wake_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> (wdt_clr && osc_en));

  p_osc_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en != asleep);

  p_wake_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |=> core_rst_req);

  p_awake_wdt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && !por_evt && !ext_rst && wdt_tmo && wdt_en)
      |=> (!flag_to && !flag_wuf && $stable(flag_pd)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_evt && !ext_rst && !(wdt_tmo && wdt_en) && !(asleep && pin_chg && woc_en)
      && !(sleep_cmd && !asleep))
      |=> ($stable(flag_to) && $stable(flag_pd) && $stable(flag_wuf) && $stable(asleep)));

endmodule

bind pdn_cause_ctl pdn_cause_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .ext_rst(ext_rst),
  .wdt_tmo(wdt_tmo), .wdt_en(wdt_en), .sleep_cmd(sleep_cmd),
  .pin_chg(pin_chg), .woc_en(woc_en), .flag_to(flag_to), .flag_pd(flag_pd),
  .flag_wuf(flag_wuf), .asleep(asleep), .osc_en(osc_en), .wdt_clr(wdt_clr),
  .core_rst_req(core_rst_req)
);

// File: tb/sim_pdn_cause_ctl.sv
`timescale 1ns/1ps
module sim_pdn_cause_ctl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_evt = 1'b0, ext_rst = 1'b0, wdt_tmo = 1'b0, wdt_en = 1'b0;
  logic sleep_cmd = 1'b0, pin_chg = 1'b0, woc_en = 1'b0;
  logic flag_to, flag_pd, flag_wuf, asleep, osc_en, wdt_clr, core_rst_req;

  always #2.5 clk = ~clk;

  pdn_cause_ctl u0 (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .ext_rst(ext_rst),
    .wdt_tmo(wdt_tmo), .wdt_en(wdt_en), .sleep_cmd(sleep_cmd),
    .pin_chg(pin_chg), .woc_en(woc_en), .flag_to(flag_to), .flag_pd(flag_pd),
    .flag_wuf(flag_wuf), .asleep(asleep), .osc_en(osc_en), .wdt_clr(wdt_clr),
    .core_rst_req(core_rst_req)
  );

  typedef struct {
    logic [6:0] v;   // {wuf,to,pd,asleep,osc_en,wdt_clr,core_rst_req}
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic m_wuf = 1'b0, m_to = 1'b1, m_pd = 1'b1, m_sl = 1'b0, m_pend = 1'b0;

  task automatic vec(input logic por, input logic ext, input logic wdt, input logic wen,
                     input logic slp, input logic pin, input logic woc, input string tag);
    exp_t e;
    logic ev, clr, old_sl;
    @(negedge clk);
    por_evt = por; ext_rst = ext; wdt_tmo = wdt; wdt_en = wen;
    sleep_cmd = slp; pin_chg = pin; woc_en = woc;
    old_sl = m_sl; ev = 1'b0; clr = 1'b0;
    if (por) begin
      m_wuf = 0; m_to = 1; m_pd = 1; ev = 1;
    end else if (ext) begin
      m_wuf = 0; ev = 1;
      if (old_sl) begin m_to = 1; m_pd = 0; end
    end else if (wdt && wen) begin
      m_wuf = 0; m_to = 0; ev = 1;
      if (old_sl) m_pd = 0;
    end else if (old_sl && pin && woc) begin
      m_wuf = 1; m_to = 1; m_pd = 0; ev = 1;
    end else if (!old_sl && slp) begin
      m_to = 1; m_pd = 0; m_sl = 1; clr = 1;
    end
    if (ev) begin
      m_sl = 0;
      clr = old_sl;
    end
    e.v = {m_wuf, m_to, m_pd, m_sl, ~m_sl, clr, m_pend};
    e.tag = tag;
    m_pend = ev;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        logic [6:0] act;
        e = q.pop_front();
        act = {flag_wuf, flag_to, flag_pd, asleep, osc_en, wdt_clr, core_rst_req};
        checks++;
        if (act !== e.v) begin
          fails++;
          $display("FAIL %s: {wuf,to,pd,sl,osc,clr,rst} actual=%b expected=%b", e.tag, act, e.v);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //      por ext wdt wen slp pin woc
    vec(0,0,0,0,0,0,0, "R1 reset state");
    vec(0,0,0,0,1,0,0, "R2 sleep entry");
    vec(0,0,0,0,0,0,0, "R11 hold asleep");
    vec(0,0,0,0,0,1,0, "R5 pin gated off");
    vec(0,0,1,0,0,0,0, "R3 watchdog gated off");
    vec(0,0,0,0,1,0,0, "R11 sleep while asleep");
    vec(0,0,0,0,0,1,1, "R5 pin wake / R8");
    vec(0,0,0,0,0,0,0, "R9 reset request after pin wake");
    vec(0,0,0,0,0,1,1, "R11 pin while awake");
    vec(0,0,0,0,1,0,0, "R2 sleep keeps wuf");
    vec(0,0,1,1,0,0,0, "R3 watchdog wake / R8");
    vec(0,0,0,0,0,0,0, "R9 reset request after watchdog wake");
    vec(1,0,0,0,0,0,0, "R1 power-on event");
    vec(0,0,0,0,0,0,0, "R9 reset request after power-on");
    vec(0,0,1,1,0,0,0, "R6 awake watchdog keeps pd");
    vec(0,0,0,0,0,0,0, "R9 reset request after awake watchdog");
    vec(0,0,0,0,1,0,0, "R2 sleep entry");
    vec(0,0,0,0,0,1,1, "R5 pin wake");
    vec(0,1,0,0,0,0,0, "R7 awake external reset");
    vec(0,0,0,0,0,0,0, "R9 reset request after external reset");
    vec(0,0,0,0,1,0,0, "R2 sleep entry");
    vec(0,1,0,0,0,0,0, "R4 external wake / R8");
    vec(0,0,0,0,1,0,0, "R2 sleep entry");
    vec(0,1,1,1,0,1,1, "R10 external beats watchdog and pin");
    vec(0,0,0,0,1,0,0, "R2 sleep entry");
    vec(0,0,1,1,0,1,1, "R10 watchdog beats pin");
    vec(0,1,0,0,1,0,0, "R10 external reset beats sleep");
    vec(0,0,0,0,1,0,0, "R2 sleep entry");
    vec(1,1,1,1,0,1,1, "R10 power-on beats all");
    vec(0,0,0,0,0,0,0, "R9 reset request after power-on");
    vec(0,0,0,0,0,0,0, "R9 single-cycle request");
    @(negedge clk);
    por_evt = 0; ext_rst = 0; wdt_tmo = 0; wdt_en = 0; sleep_cmd = 0; pin_chg = 0; woc_en = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule